// File: doc/BRIEF.md
# Round-Robin Header Channel Allocator

This block binds packets to output channels inside a wormhole router. Each flit buffer that receives a header flit raises a pending request. Every clock the block picks one pending buffer in rotating order and reads that buffer's 8-bit destination. It looks the destination up in a routing table. If the output channel named there is unowned, it makes the buffer the channel's owner. An output channel is one (physical link, virtual channel) pair. The transmitter side later frees the channel when the packet's tail has gone.

The routing table has one 4-bit entry per destination and is filled by the host after reset. The first 256 bytes written after reset go to destinations 0 to 255 in that order, and later writes are dropped. A field holding the code 3 marks the packet as local or undeliverable. Such a request is retired and a separate pulse reports it, so no channel is claimed. A request whose channel is owned stays pending and is tried again when the rotation comes back to it.

Top module: `hdr_chan_alloc`

## Requirements
- R1: While reset is low at a clock edge, the block clears all pending requests, clears all channel ownership and the table write count, and points the rotation at buffer 0. After such an edge `grant_valid` and `local_valid` are 0.
- R2: A 1 on `hdr_set[i]` at a clock edge makes `req_pend[i]` 1 after that edge. A set arriving at the same edge as a retirement of that buffer wins.
- R3: The k-th table write after reset (k from 0 to 255) stores bits [3:0] of `tbl_wdata` as the entry for destination k, and bits above 3 are ignored. Writes after the 256th have no effect. `tbl_loaded` goes to 1 after the 256th write and stays there. No request is served while `tbl_loaded` is 0.
- R4: At each edge with the table loaded, the block serves the first pending buffer at or after the rotation pointer, wrapping past the last buffer. The pointer then moves to the buffer after the one served, and at most one buffer is served per edge.
- R5: If the served buffer's channel is unowned, then after the edge `grant_valid` is 1 for one cycle with `out_buf`, `out_pc` and `out_vc` naming the buffer and channel. The channel shows as mapped with that buffer as owner, and the buffer's request is cleared.
- R6: If the served buffer's channel is owned, nothing is granted, ownership is unchanged and the request stays pending, but the rotation pointer still moves past that buffer.
- R7: An entry whose physical field (bits [3:2]) or virtual field (bits [1:0]) equals 3 retires the request with a one-cycle `local_valid` pulse carrying the buffer and the entry fields. No channel is claimed.
- R8: A 1 on `oc_release[c]` at an edge frees channel c after that edge.
- R9: Channel c corresponds to physical channel c / 3 and virtual channel c mod 3. `oc_owner` holds owner c in bits [4c+3:4c].
- R10: `grant_valid` and `local_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_set | input | 12 | One bit per buffer: header flit arrived |
| hdr_dest | input | 96 | Destination of each buffer's header, 8 bits per buffer, buffer i in bits [8i+7:8i] |
| tbl_wr | input | 1 | Host table write strobe |
| tbl_wdata | input | 8 | Host write byte, entry in bits [3:0] |
| oc_release | input | 9 | One bit per output channel: free it |
| tbl_loaded | output | 1 | Routing table fully written |
| req_pend | output | 12 | Pending request per buffer |
| grant_valid | output | 1 | One-cycle pulse: a channel was bound |
| local_valid | output | 1 | One-cycle pulse: request retired as local/invalid |
| out_buf | output | 4 | Buffer served by the pulse |
| out_pc | output | 2 | Physical field of the served entry |
| out_vc | output | 2 | Virtual field of the served entry |
| oc_mapped | output | 9 | Channel owned flags |
| oc_owner | output | 36 | Owning buffer per channel, 4 bits each |

## Verification
The assertions assume a buffer's `hdr_dest` slice stays stable from the edge that sets its request until the edge that retires it. They also assume `hdr_set[i]` is raised only for a buffer with no pending request. The stimulus enforces both: it changes a destination only when it raises that buffer's set bit, and only for buffers the reference model shows idle. Releases are issued freely, including on unowned channels, because a release of an unowned channel is harmless under R8.

// File: rtl/hca_pkg.sv
// Shared definitions for the header channel allocator.
package hca_pkg;
    // Width of each field of a routing-table entry.
    localparam int FIELD_W = 2;
    localparam int ENTRY_W = 2 * FIELD_W;

    // One routing-table entry: physical link in the upper field, VC in the lower.
    typedef struct packed {
        logic [FIELD_W-1:0] pc;
        logic [FIELD_W-1:0] vc;
    } route_entry_t;
endpackage

// File: rtl/hca_rr_pick.sv
// Rotating-priority finder.
// Returns the first set bit of req at or after index start, wrapping past N-1.
// Assumes start < N.
module hca_rr_pick #(
    parameter int N = 12,
    parameter int W = 4
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] start,
    output logic         found,
    output logic [W-1:0] pick
);
    // Walk the request vector once from the start position.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = int'(start) + i;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = W'(idx);
            end
        end
    end
endmodule

// File: rtl/hca_route_table.sv
// Host-loaded routing table.
// The first DEPTH writes after reset fill addresses 0..DEPTH-1 in order and
// later writes are dropped. Contents are not reset. They are valid once
// loaded is high. The read port is combinational.
module hca_route_table
    import hca_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WR_W   = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WR_W-1:0]   wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output route_entry_t      rd_entry,
    output logic              loaded
);
    logic [ADDR_W:0] wr_cnt;
    route_entry_t    mem [DEPTH];
    logic            wr_take;

    assign wr_take  = rst_n && wr && !wr_cnt[ADDR_W];
    assign loaded   = wr_cnt[ADDR_W];
    assign rd_entry = mem[rd_addr];

    // Count accepted writes; the top bit doubles as the loaded flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_cnt <= '0;
        else if (wr_take) wr_cnt <= wr_cnt + 1'b1;
    end

    // Store the low entry bits of each accepted byte at the running address.
    always_ff @(posedge clk) begin
        if (wr_take) mem[wr_cnt[ADDR_W-1:0]] <= route_entry_t'(wdata[ENTRY_W-1:0]);
    end
endmodule

// File: rtl/hca_chan_map.sv
// Output-channel ownership store.
// One valid flag and one owner index per output channel. A bind request
// beats a release on the same channel in the same cycle. The caller binds
// only channels that are currently free.
module hca_chan_map #(
    parameter int NUM_OC = 9,
    parameter int OC_W   = 4,
    parameter int BUF_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bind_en,
    input  logic [OC_W-1:0]         bind_oc,
    input  logic [BUF_W-1:0]        bind_buf,
    input  logic [NUM_OC-1:0]       release_vec,
    output logic [NUM_OC-1:0]       mapped,
    output logic [NUM_OC*BUF_W-1:0] owner
);
    // Update every channel's flag and owner each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mapped <= '0;
            owner  <= '0;
        end else begin
            for (int o = 0; o < NUM_OC; o++) begin
                if (bind_en && bind_oc == OC_W'(o)) begin
                    mapped[o]                 <= 1'b1;
                    owner[o*BUF_W +: BUF_W]   <= bind_buf;
                end else if (release_vec[o]) begin
                    mapped[o] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/hdr_chan_alloc.sv
// Header channel allocator top.
// Keeps one pending flag per flit buffer and serves one per cycle in
// rotating order once the routing table is loaded. It binds the buffer to
// the looked-up output channel when that channel is free, retires it as
// local when an entry field holds the reserved top code, and otherwise
// leaves it pending. Assumes each buffer's destination is stable while its
// flag is set.
module hdr_chan_alloc
    import hca_pkg::*;
#(
    parameter int NUM_BUF = 12,
    parameter int NUM_PC  = 3,
    parameter int NUM_VC  = 3,
    parameter int ADDR_W  = 8,
    parameter int WR_W    = 8,
    localparam int NUM_OC = NUM_PC * NUM_VC,
    localparam int BUF_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int OC_W   = (NUM_OC > 1) ? $clog2(NUM_OC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_BUF-1:0]        hdr_set,
    input  logic [NUM_BUF*ADDR_W-1:0] hdr_dest,
    input  logic                      tbl_wr,
    input  logic [WR_W-1:0]           tbl_wdata,
    input  logic [NUM_OC-1:0]         oc_release,
    output logic                      tbl_loaded,
    output logic [NUM_BUF-1:0]        req_pend,
    output logic                      grant_valid,
    output logic                      local_valid,
    output logic [BUF_W-1:0]          out_buf,
    output logic [FIELD_W-1:0]        out_pc,
    output logic [FIELD_W-1:0]        out_vc,
    output logic [NUM_OC-1:0]         oc_mapped,
    output logic [NUM_OC*BUF_W-1:0]   oc_owner
);
    logic [BUF_W-1:0]  rr_ptr;
    logic              pick_found;
    logic [BUF_W-1:0]  pick_buf;
    logic [ADDR_W-1:0] pick_dest;
    route_entry_t      pick_entry;
    logic              is_local;
    logic [OC_W-1:0]   pick_oc;
    logic              oc_busy;
    logic              try_serve;
    logic              do_grant;
    logic              do_local;
    logic [NUM_BUF-1:0] retire_vec;

    hca_rr_pick #(.N(NUM_BUF), .W(BUF_W)) u_pick (
        .req   (req_pend),
        .start (rr_ptr),
        .found (pick_found),
        .pick  (pick_buf)
    );

    // Destination of the buffer chosen this cycle.
    assign pick_dest = hdr_dest[int'(pick_buf)*ADDR_W +: ADDR_W];

    hca_route_table #(.ADDR_W(ADDR_W), .WR_W(WR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (tbl_wr),
        .wdata    (tbl_wdata),
        .rd_addr  (pick_dest),
        .rd_entry (pick_entry),
        .loaded   (tbl_loaded)
    );

    // Decode the entry into a channel index, or flag it as local/invalid.
    always_comb begin
        is_local = (int'(pick_entry.pc) >= NUM_PC) || (int'(pick_entry.vc) >= NUM_VC);
        pick_oc  = OC_W'(int'(pick_entry.pc) * NUM_VC + int'(pick_entry.vc));
        oc_busy  = 1'b1;
        for (int o = 0; o < NUM_OC; o++) begin
            if (!is_local && pick_oc == OC_W'(o)) oc_busy = oc_mapped[o];
        end
    end

    assign try_serve  = tbl_loaded && pick_found;
    assign do_grant   = try_serve && !is_local && !oc_busy;
    assign do_local   = try_serve && is_local;
    assign retire_vec = (do_grant || do_local) ? (NUM_BUF'(1) << pick_buf) : '0;

    hca_chan_map #(.NUM_OC(NUM_OC), .OC_W(OC_W), .BUF_W(BUF_W)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .bind_en     (do_grant),
        .bind_oc     (pick_oc),
        .bind_buf    (pick_buf),
        .release_vec (oc_release),
        .mapped      (oc_mapped),
        .owner       (oc_owner)
    );

    // Pending flags: new headers set, served buffers clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) req_pend <= '0;
        else        req_pend <= (req_pend & ~retire_vec) | hdr_set;
    end

    // Rotation pointer moves past whichever buffer was examined.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (try_serve) begin
            rr_ptr <= (int'(pick_buf) == NUM_BUF - 1) ? '0 : pick_buf + 1'b1;
        end
    end

    // Result pulses and the fields they carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            local_valid <= 1'b0;
            out_buf     <= '0;
            out_pc      <= '0;
            out_vc      <= '0;
        end else begin
            grant_valid <= do_grant;
            local_valid <= do_local;
            if (try_serve) begin
                out_buf <= pick_buf;
                out_pc  <= pick_entry.pc;
                out_vc  <= pick_entry.vc;
            end
        end
    end
endmodule

// File: rtl/hca_checker.sv
// Property checker for the header channel allocator, bound to the top.
// Holds one-cycle copies of inputs and channel state so that each property
// compares results against the cycle that produced them.
module hca_checker
    import hca_pkg::*;
#(
    parameter int NUM_BUF = 12,
    parameter int NUM_PC  = 3,
    parameter int NUM_VC  = 3,
    parameter int ADDR_W  = 8,
    parameter int WR_W    = 8,
    localparam int NUM_OC = NUM_PC * NUM_VC,
    localparam int BUF_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_BUF-1:0]      hdr_set,
    input logic [NUM_OC-1:0]       oc_release,
    input logic                    tbl_loaded,
    input logic [NUM_BUF-1:0]      req_pend,
    input logic                    grant_valid,
    input logic                    local_valid,
    input logic [BUF_W-1:0]        out_buf,
    input logic [FIELD_W-1:0]      out_pc,
    input logic [FIELD_W-1:0]      out_vc,
    input logic [NUM_OC-1:0]       oc_mapped,
    input logic [NUM_OC*BUF_W-1:0] oc_owner
);
    logic [NUM_BUF-1:0] prev_set;
    logic [NUM_OC-1:0]  prev_map;
    logic [NUM_OC-1:0]  prev_rel;
    int                 g_oc;

    // Remember last cycle's sets, ownership and releases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_set <= '0;
            prev_map <= '0;
            prev_rel <= '0;
        end else begin
            prev_set <= hdr_set;
            prev_map <= oc_mapped;
            prev_rel <= oc_release;
        end
    end

    assign g_oc = int'(out_pc) * NUM_VC + int'(out_vc);

    // R10: at most one result pulse per cycle.
    p_single_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid && local_valid));

    // R3: nothing is served before the table is full.
    p_needs_table_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid || local_valid) |-> tbl_loaded);

    // R3: the loaded state persists until reset.
    p_loaded_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_loaded |=> tbl_loaded);

    // R9: a grant names a real channel.
    p_grant_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (int'(out_pc) < NUM_PC && int'(out_vc) < NUM_VC));

    // R5: a granted channel is owned by the granted buffer.
    p_grant_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (oc_mapped[g_oc] && oc_owner[g_oc*BUF_W +: BUF_W] == out_buf));

    // R6: a grant only goes to a channel that was free.
    p_grant_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !prev_map[g_oc]);

    // R5: a served buffer's request is gone unless re-raised.
    p_retire_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_valid || local_valid) && !prev_set[out_buf]) |-> !req_pend[out_buf]);

    // R7: the local pulse only comes with a reserved field code.
    p_local_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        local_valid |-> (int'(out_pc) >= NUM_PC || int'(out_vc) >= NUM_VC));

    // R8: a released channel is free afterwards unless re-granted.
    for (genvar o = 0; o < NUM_OC; o++) begin : g_rel
        p_release_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (prev_rel[o] && !(grant_valid && g_oc == o)) |-> !oc_mapped[o]);
    end
endmodule

bind hdr_chan_alloc hca_checker #(
    .NUM_BUF (NUM_BUF),
    .NUM_PC  (NUM_PC),
    .NUM_VC  (NUM_VC),
    .ADDR_W  (ADDR_W),
    .WR_W    (WR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_set     (hdr_set),
    .oc_release  (oc_release),
    .tbl_loaded  (tbl_loaded),
    .req_pend    (req_pend),
    .grant_valid (grant_valid),
    .local_valid (local_valid),
    .out_buf     (out_buf),
    .out_pc      (out_pc),
    .out_vc      (out_vc),
    .oc_mapped   (oc_mapped),
    .oc_owner    (oc_owner)
);

// File: tb/hdr_chan_alloc_test.sv
// Bench: behavioural reference model compared with the design every cycle.
module hdr_chan_alloc_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB  = 12;
    localparam int NPC = 3;
    localparam int NVC = 3;
    localparam int NOC = NPC * NVC;
    localparam int BW  = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NB-1:0]    hdr_set;
    logic [NB*8-1:0]  hdr_dest;
    logic             tbl_wr;
    logic [7:0]       tbl_wdata;
    logic [NOC-1:0]   oc_release;
    logic             tbl_loaded;
    logic [NB-1:0]    req_pend;
    logic             grant_valid;
    logic             local_valid;
    logic [BW-1:0]    out_buf;
    logic [1:0]       out_pc;
    logic [1:0]       out_vc;
    logic [NOC-1:0]   oc_mapped;
    logic [NOC*BW-1:0] oc_owner;
    logic [7:0]       dest_a [NB];

    int vectors = 0;
    int miscompares = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Reference model state.
    int m_flag [NB];
    int m_ptr, m_cnt;
    int m_tbl [256];
    int m_map [NOC];
    int m_own [NOC];
    int m_gv, m_lv, m_buf, m_pc, m_vc;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar g = 0; g < NB; g++) begin : g_dest
        assign hdr_dest[g*8 +: 8] = dest_a[g];
    end

    hdr_chan_alloc uut (
        .clk(clk), .rst_n(rst_n), .hdr_set(hdr_set), .hdr_dest(hdr_dest),
        .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata), .oc_release(oc_release),
        .tbl_loaded(tbl_loaded), .req_pend(req_pend), .grant_valid(grant_valid),
        .local_valid(local_valid), .out_buf(out_buf), .out_pc(out_pc),
        .out_vc(out_vc), .oc_mapped(oc_mapped), .oc_owner(oc_owner)
    );

    function automatic int entry_of(int a);
        return (a ^ (a >> 4)) & 15;
    endfunction

    // Advance the model by one clock edge.
    always @(posedge clk) begin
        int s, e, pc, vc, oc, goc;
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) m_flag[i] = 0;
            for (int o = 0; o < NOC; o++) begin m_map[o] = 0; m_own[o] = 0; end
            m_ptr = 0; m_cnt = 0; m_gv = 0; m_lv = 0;
        end else begin
            s = -1; goc = 0; m_gv = 0; m_lv = 0;
            if (m_cnt == 256) begin
                for (int i = 0; i < NB; i++)
                    if (s < 0 && m_flag[(m_ptr + i) % NB] != 0) s = (m_ptr + i) % NB;
            end
            if (s >= 0) begin
                e = m_tbl[dest_a[s]];
                pc = e / 4; vc = e % 4;
                m_buf = s; m_pc = pc; m_vc = vc;
                if (pc >= NPC || vc >= NVC) begin
                    m_lv = 1; m_flag[s] = 0;
                end else begin
                    oc = pc * NVC + vc;
                    if (m_map[oc] == 0) begin m_gv = 1; goc = oc; m_flag[s] = 0; end
                end
                m_ptr = (s + 1) % NB;
            end
            for (int o = 0; o < NOC; o++) if (oc_release[o]) m_map[o] = 0;
            if (m_gv != 0) begin m_map[goc] = 1; m_own[goc] = s; end
            for (int i = 0; i < NB; i++) if (hdr_set[i]) m_flag[i] = 1;
            if (tbl_wr && m_cnt < 256) begin m_tbl[m_cnt] = tbl_wdata & 15; m_cnt++; end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(tbl_loaded == (m_cnt == 256), "R3 tbl_loaded", tbl_loaded, m_cnt == 256);
            for (int i = 0; i < NB; i++)
                chk(req_pend[i] == (m_flag[i] != 0), "R2 req_pend", req_pend[i], m_flag[i]);
            chk(grant_valid == (m_gv != 0), "R4 grant_valid", grant_valid, m_gv);
            chk(local_valid == (m_lv != 0), "R7 local_valid", local_valid, m_lv);
            chk(!(grant_valid && local_valid), "R10 both pulses", 1, 0);
            if (m_gv != 0 || m_lv != 0) begin
                chk(out_buf == m_buf, "R4 out_buf", out_buf, m_buf);
                chk(out_pc == m_pc, "R9 out_pc", out_pc, m_pc);
                chk(out_vc == m_vc, "R9 out_vc", out_vc, m_vc);
            end
            for (int o = 0; o < NOC; o++) begin
                chk(oc_mapped[o] == (m_map[o] != 0), "R8 oc_mapped", oc_mapped[o], m_map[o]);
                if (m_map[o] != 0)
                    chk(oc_owner[o*BW +: BW] == m_own[o], "R5 oc_owner",
                        oc_owner[o*BW +: BW], m_own[o]);
            end
        end
    end

    task automatic raise(int b, int d);
        hdr_set[b] = 1'b1;
        dest_a[b]  = d[7:0];
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hdr_set = '0;
            oc_release = '0;
        end
    endtask

    initial begin
        rst_n = 1'b0; hdr_set = '0; tbl_wr = 1'b0; tbl_wdata = '0; oc_release = '0;
        for (int i = 0; i < NB; i++) dest_a[i] = '0;
        repeat (3) @(negedge clk);
        // R1: state after reset edges.
        chk(tbl_loaded == 0 && req_pend == 0 && oc_mapped == 0, "R1 reset state",
            int'(req_pend), 0);
        chk(grant_valid == 0 && local_valid == 0, "R1 reset pulses", grant_valid, 0);
        cmp_on = 1'b1;
        rst_n = 1'b1;
        step(1);
        // R2/R3: requests before the table is loaded wait.
        raise(0, 8'h05); raise(5, 8'h0C);
        step(4);
        chk(req_pend[0] && req_pend[5] && !grant_valid, "R3 held before load", req_pend, 12'h021);
        // R3: load 256 entries plus 44 extra writes that must be dropped.
        for (int k = 0; k < 300; k++) begin
            tbl_wr = 1'b1;
            tbl_wdata = (k < 256) ? {4'hA, 4'(entry_of(k))} : {4'h5, ~4'(entry_of(k - 256))};
            @(negedge clk);
        end
        tbl_wr = 1'b0;
        chk(tbl_loaded == 1, "R3 loaded", tbl_loaded, 1);
        step(4);
        chk(oc_mapped[4] && oc_owner[4*BW +: BW] == 0, "R5 grant to channel 4", oc_mapped, 16);
        chk(req_pend[5] == 0, "R7 local retired", req_pend[5], 0);
        // R6: two buffers contend for channel 0.
        raise(3, 8'h00); raise(7, 8'h11);
        step(4);
        chk(oc_mapped[0] && (req_pend[3] ^ req_pend[7]), "R6 loser stays pending",
            int'(req_pend), 0);
        // R8: freeing channel 0 lets the waiter through.
        oc_release[0] = 1'b1;
        step(4);
        chk(oc_mapped[0] && !req_pend[3] && !req_pend[7], "R8 waiter granted", int'(req_pend), 0);
        oc_release = '1;
        step(2);
        // R4: three requests served on consecutive edges.
        raise(2, 8'h10); raise(6, 8'h02); raise(10, 8'h04);
        step(5);
        chk(oc_mapped[1] && oc_mapped[2] && oc_mapped[3], "R4 all three served",
            int'(oc_mapped), 14);
        // Random traffic with releases.
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < NB; i++)
                if (m_flag[i] == 0 && ($urandom % 8) == 0) raise(i, int'($urandom % 256));
            for (int o = 0; o < NOC; o++)
                if (($urandom % 6) == 0) oc_release[o] = 1'b1;
            @(negedge clk);
            hdr_set = '0;
            oc_release = '0;
        end
        step(20);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run is reported as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog R4 actual %0d expected %0d", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule